// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KB pages. It does this by reading a page directory entry and then a page table entry from memory over a simple port that allows one access at a time. The caller supplies the frame number of the directory and a request made of the address, a write flag and a user flag. The walker answers with a one-cycle `done` pulse. With that pulse it gives either the physical address or a fault, and a fault carries its level, its cause and the linear address that caused it.

Entry permissions are checked at both levels, so the directory entry and the table entry each restrict the access. When a translation succeeds, the walker writes the accessed flag, and for writes the dirty flag, back into the entries in memory. It writes an entry only when one of those flags actually changes. The directory entry is always written before the table entry. Any fault leaves memory untouched.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from byte address {dir_base, va[31:22], 2'b00}. The table entry is read from {directory entry[31:12], va[21:12], 2'b00}.
- R2: On success, resp_paddr = {table entry[31:12], va[11:0]}.
- R3: Entry bit 0 is the present flag. If it is 0 in the directory entry, the walk faults with fault_level 0 and fault_cause 1. If it is 0 in the table entry, the walk faults with fault_level 1 and fault_cause 1. A not-present fault takes priority over every other cause.
- R4: A user access (req_user=1) through an entry whose bit 2 is 0 faults with fault_cause 2 at that entry's level.
- R5: A user write through an entry whose bit 1 is 0 faults with fault_cause 3 at that entry's level. Cause 2 wins over cause 3. Supervisor accesses ignore bit 1 at both levels.
- R6: After a successful walk, bit 5 is set in both entries in memory. For a write, bit 6 is also set in the table entry. No other bit of either entry changes.
- R7: An entry is written back only when its new value differs from the value read. When both entries are written, the directory entry is written first.
- R8: A faulting walk writes nothing to memory. It reports resp_fault=1, resp_paddr=0 and fault_vaddr equal to the request address. A successful walk reports fault_cause 0 and fault_vaddr 0.
- R9: req_ready is high only while the walker is idle. A request is taken when req_valid and req_ready are both high. done is a one-cycle pulse, and req_ready is already high in that cycle.
- R10: Each walk reads the directory entry and then, only if the walk did not fault at the directory level, the table entry. mem_req, mem_addr and mem_we stay stable until mem_ack, and only one access is outstanding at a time.
- R11: After reset, req_ready=1, done=0 and mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 20 | Frame number of the page directory, sampled when a request is accepted |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Memory finished the pending access |
| mem_rdata | input | 32 | Read data, valid while mem_ack is high |
| done | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| fault_level | output | 1 | 0 = directory entry, 1 = table entry |
| fault_cause | output | 2 | 0 none, 1 not present, 2 user protection, 3 write protection |
| fault_vaddr | output | 32 | Linear address that faulted, 0 on success |

## Verification
The assertions assume that memory raises mem_ack for exactly one cycle per access, and only while mem_req is high. They also assume that a new request is presented only when req_ready is high. The bench's memory model follows these rules: it serves a pending access after a random wait of zero to two cycles, and it never acknowledges in two consecutive cycles. The stimulus places directories and tables in a small memory image and points every directory entry at one of those tables, so each walk reads defined data.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry flag positions; the walker and the memory image both depend on them
  localparam int BIT_P  = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;

  localparam int NUM_LEVELS = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_USER   = 2'd2,
    CAUSE_WRITE  = 2'd3
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_CHK,
    ST_TBL_RD,
    ST_TBL_CHK,
    ST_DIR_WB,
    ST_TBL_WB,
    ST_RESP
  } walk_state_e;

endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  input  logic               is_user,
  output logic               fault,
  output fault_cause_e       cause
);

  // Priority: absent, then user protection, then write protection
  always_comb begin
    cause = CAUSE_NONE;
    if (!entry[BIT_P])
      cause = CAUSE_ABSENT;
    else if (is_user && !entry[BIT_US])
      cause = CAUSE_USER;
    else if (is_user && is_write && !entry[BIT_RW])
      cause = CAUSE_WRITE;
  end

  assign fault = (cause != CAUSE_NONE);

endmodule

// File: rtl/ptw_flag_merge.sv
module ptw_flag_merge
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] dir_ent,
  input  logic [ENTRY_W-1:0] tbl_ent,
  input  logic               is_write,
  output logic [ENTRY_W-1:0] dir_new,
  output logic [ENTRY_W-1:0] tbl_new,
  output logic               dir_upd,
  output logic               tbl_upd
);

  localparam logic [ENTRY_W-1:0] MASK_A = ENTRY_W'(1) << BIT_A;
  localparam logic [ENTRY_W-1:0] MASK_D = ENTRY_W'(1) << BIT_D;

  always_comb begin
    dir_new = dir_ent | MASK_A;
    tbl_new = tbl_ent | MASK_A | (is_write ? MASK_D : '0);
    dir_upd = (dir_new != dir_ent);
    tbl_upd = (tbl_new != tbl_ent);
  end

endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  output logic              fin
);

  assign fin = mem_req && mem_ack;

  // A new start takes priority so accesses may run back to back
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end else if (fin) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-OFFS_W-1:0] dir_base,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_vaddr,
  input  logic                     req_write,
  input  logic                     req_user,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [ADDR_W-1:0]        mem_wdata,
  input  logic                     mem_ack,
  input  logic [ADDR_W-1:0]        mem_rdata,
  output logic                     done,
  output logic                     resp_fault,
  output logic [ADDR_W-1:0]        resp_paddr,
  output logic                     fault_level,
  output logic [1:0]               fault_cause,
  output logic [ADDR_W-1:0]        fault_vaddr
);

  localparam int FRAME_W     = ADDR_W - OFFS_W;
  localparam int IDX_W       = FRAME_W / NUM_LEVELS;
  localparam int ENTRY_BYTES = ADDR_W / 8;
  localparam int ENT_SH      = $clog2(ENTRY_BYTES);

  walk_state_e st, st_n;

  logic [ADDR_W-1:0] va_q;
  logic              wr_q, usr_q;
  logic [ADDR_W-1:0] dir_addr_q;
  logic [ADDR_W-1:0] ent_q [NUM_LEVELS];
  logic              flt_q, lvl_q;
  fault_cause_e      cause_q;

  logic              mp_start, mp_we, mp_fin;
  logic [ADDR_W-1:0] mp_addr, mp_wdata;

  logic [NUM_LEVELS-1:0] lvl_fault;
  fault_cause_e          lvl_cause [NUM_LEVELS];

  logic [ADDR_W-1:0] dir_new, tbl_new;
  logic              dir_upd, tbl_upd;

  logic [ADDR_W-1:0] tbl_addr, paddr;

  assign tbl_addr  = {ent_q[0][ADDR_W-1 -: FRAME_W], va_q[OFFS_W +: IDX_W], {ENT_SH{1'b0}}};
  assign paddr     = {ent_q[1][ADDR_W-1 -: FRAME_W], va_q[OFFS_W-1:0]};
  assign req_ready = (st == ST_IDLE);

  // One permission checker per level
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    ptw_perm_check #(.ENTRY_W(ADDR_W)) u_perm (
      .entry    (ent_q[g]),
      .is_write (wr_q),
      .is_user  (usr_q),
      .fault    (lvl_fault[g]),
      .cause    (lvl_cause[g])
    );
  end

  ptw_flag_merge #(.ENTRY_W(ADDR_W)) u_merge (
    .dir_ent  (ent_q[0]),
    .tbl_ent  (ent_q[1]),
    .is_write (wr_q),
    .dir_new  (dir_new),
    .tbl_new  (tbl_new),
    .dir_upd  (dir_upd),
    .tbl_upd  (tbl_upd)
  );

  ptw_mem_port #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .start       (mp_start),
    .start_we    (mp_we),
    .start_addr  (mp_addr),
    .start_wdata (mp_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .fin         (mp_fin)
  );

  // Sequencer: next state and memory access launch
  always_comb begin
    st_n     = st;
    mp_start = 1'b0;
    mp_we    = 1'b0;
    mp_addr  = tbl_addr;
    mp_wdata = '0;
    unique case (st)
      ST_IDLE: begin
        mp_addr = {dir_base, req_vaddr[ADDR_W-1 -: IDX_W], {ENT_SH{1'b0}}};
        if (req_valid) begin
          mp_start = 1'b1;
          st_n     = ST_DIR_RD;
        end
      end
      ST_DIR_RD:  if (mp_fin) st_n = ST_DIR_CHK;
      ST_DIR_CHK: begin
        if (lvl_fault[0]) begin
          st_n = ST_RESP;
        end else begin
          mp_start = 1'b1;
          st_n     = ST_TBL_RD;
        end
      end
      ST_TBL_RD:  if (mp_fin) st_n = ST_TBL_CHK;
      ST_TBL_CHK: begin
        if (lvl_fault[1]) begin
          st_n = ST_RESP;
        end else if (dir_upd) begin
          mp_start = 1'b1;
          mp_we    = 1'b1;
          mp_addr  = dir_addr_q;
          mp_wdata = dir_new;
          st_n     = ST_DIR_WB;
        end else if (tbl_upd) begin
          mp_start = 1'b1;
          mp_we    = 1'b1;
          mp_wdata = tbl_new;
          st_n     = ST_TBL_WB;
        end else begin
          st_n = ST_RESP;
        end
      end
      ST_DIR_WB: begin
        if (mp_fin) begin
          if (tbl_upd) begin
            mp_start = 1'b1;
            mp_we    = 1'b1;
            mp_wdata = tbl_new;
            st_n     = ST_TBL_WB;
          end else begin
            st_n = ST_RESP;
          end
        end
      end
      ST_TBL_WB: if (mp_fin) st_n = ST_RESP;
      ST_RESP:   st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      dir_addr_q  <= '0;
      ent_q[0]    <= '0;
      ent_q[1]    <= '0;
      flt_q       <= 1'b0;
      lvl_q       <= 1'b0;
      cause_q     <= CAUSE_NONE;
      done        <= 1'b0;
      resp_fault  <= 1'b0;
      resp_paddr  <= '0;
      fault_level <= 1'b0;
      fault_cause <= 2'd0;
      fault_vaddr <= '0;
    end else begin
      st   <= st_n;
      done <= 1'b0;

      if (st == ST_IDLE && req_valid) begin
        va_q       <= req_vaddr;
        wr_q       <= req_write;
        usr_q      <= req_user;
        dir_addr_q <= mp_addr;
        flt_q      <= 1'b0;
        lvl_q      <= 1'b0;
        cause_q    <= CAUSE_NONE;
      end

      if (st == ST_DIR_RD && mp_fin) ent_q[0] <= mem_rdata;
      if (st == ST_TBL_RD && mp_fin) ent_q[1] <= mem_rdata;

      if (st == ST_DIR_CHK && lvl_fault[0]) begin
        flt_q   <= 1'b1;
        lvl_q   <= 1'b0;
        cause_q <= lvl_cause[0];
      end
      if (st == ST_TBL_CHK && lvl_fault[1]) begin
        flt_q   <= 1'b1;
        lvl_q   <= 1'b1;
        cause_q <= lvl_cause[1];
      end

      if (st == ST_RESP) begin
        done        <= 1'b1;
        resp_fault  <= flt_q;
        fault_level <= lvl_q;
        fault_cause <= cause_q;
        fault_vaddr <= flt_q ? va_q : '0;
        resp_paddr  <= flt_q ? '0 : paddr;
      end
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wb_present,
  input logic              wb_accessed,
  input logic              mem_ack,
  input logic              done,
  input logic              resp_fault,
  input logic [OFFS_W-1:0] paddr_offs,
  input logic [1:0]        fault_cause,
  input logic [ADDR_W-1:0] fault_vaddr
);

  logic [ADDR_W-1:0] acc_va;

  always_ff @(posedge clk) begin
    if (rst) acc_va <= '0;
    else if (req_valid && req_ready) acc_va <= req_vaddr;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req); // R9

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R9

  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> wb_present && wb_accessed); // R6

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
    done && resp_fault |-> fault_cause != 2'd0 && fault_vaddr == acc_va); // R8

  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (rst)
    done && !resp_fault |-> paddr_offs == acc_va[OFFS_W-1:0]); // R2

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .wb_present  (mem_wdata[0]),
  .wb_accessed (mem_wdata[5]),
  .mem_ack     (mem_ack),
  .done        (done),
  .resp_fault  (resp_fault),
  .paddr_offs  (resp_paddr[OFFS_W-1:0]),
  .fault_cause (fault_cause),
  .fault_vaddr (fault_vaddr)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] dir_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, resp_fault, fault_level;
  logic [31:0] resp_paddr, fault_vaddr;
  logic [1:0]  fault_cause;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .fault_level(fault_level), .fault_cause(fault_cause), .fault_vaddr(fault_vaddr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Memory image: 8 frames of 4 KB
  logic [31:0] mem [0:8191];
  int unsigned wr_cnt = 0;
  int unsigned rd_cnt = 0;
  logic [31:0] wr_log [0:15];
  int unsigned lat = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        if (mem_we) begin
          mem[mem_addr[14:2]]  <= mem_wdata;
          wr_log[wr_cnt % 16]  <= mem_addr;
          wr_cnt               <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[14:2]];
          rd_cnt    <= rd_cnt + 1;
        end
        mem_ack <= 1'b1;
        lat     <= $urandom % 3;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cause_of(input logic [31:0] e, input logic w, input logic u);
    if (!e[0]) return 2'd1;
    if (u && !e[2]) return 2'd2;
    if (u && w && !e[1]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic walk(input logic [19:0] base, input logic [31:0] va, input logic w, input logic u);
    logic [31:0] a_dir, a_tbl, pde, pte, e_pde, e_pte, e_pa, e_fva;
    logic [1:0]  c0, c1, e_cause;
    logic        e_flt, e_lvl;
    int unsigned e_wr, e_rd, w0, r0, t;
    a_dir = {base, va[31:22], 2'b00};
    pde   = mem[a_dir[14:2]];
    a_tbl = {pde[31:12], va[21:12], 2'b00};
    pte   = mem[a_tbl[14:2]];
    c0 = cause_of(pde, w, u);
    c1 = cause_of(pte, w, u);
    e_pde = pde; e_pte = pte; e_wr = 0; e_pa = 0; e_fva = va;
    e_rd  = (c0 != 0) ? 1 : 2;
    if (c0 != 0) begin
      e_flt = 1; e_lvl = 0; e_cause = c0;
    end else if (c1 != 0) begin
      e_flt = 1; e_lvl = 1; e_cause = c1;
    end else begin
      e_flt = 0; e_lvl = 0; e_cause = 0; e_fva = 0;
      e_pa  = {pte[31:12], va[11:0]};
      e_pde = pde | 32'h20;
      e_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
      e_wr  = int'(e_pde != pde) + int'(e_pte != pte);
    end
    w0 = wr_cnt; r0 = rd_cnt;

    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready before request", {31'b0, req_ready}, 32'd1);
    dir_base = base; req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R9 busy after accept", {31'b0, req_ready}, 32'd0);
    t = 0;
    while (done !== 1'b1 && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (done !== 1'b1) begin
      chk(1'b0, "R9 done timeout", 32'd0, 32'd1);
      return;
    end
    chk(resp_fault === e_flt, "R3/R4/R5 fault flag", {31'b0, resp_fault}, {31'b0, e_flt});
    chk(fault_cause === e_cause,
        e_cause == 1 ? "R3 cause" : e_cause == 2 ? "R4 cause" : "R5 cause",
        {30'b0, fault_cause}, {30'b0, e_cause});
    if (e_flt) chk(fault_level === e_lvl, "R3 level", {31'b0, fault_level}, {31'b0, e_lvl});
    chk(resp_paddr === e_pa, e_flt ? "R8 paddr zero" : "R2 paddr", resp_paddr, e_pa);
    chk(fault_vaddr === e_fva, "R8 fault vaddr", fault_vaddr, e_fva);
    chk(mem[a_dir[14:2]] === e_pde, "R1 R6 directory entry after walk", mem[a_dir[14:2]], e_pde);
    if (c0 == 0) chk(mem[a_tbl[14:2]] === e_pte, "R1 R6 table entry after walk", mem[a_tbl[14:2]], e_pte);
    chk(wr_cnt - w0 == e_wr, e_flt ? "R8 no write on fault" : "R7 write count", wr_cnt - w0, e_wr);
    chk(rd_cnt - r0 == e_rd, "R10 read count", rd_cnt - r0, e_rd);
    if (e_wr == 2) chk(wr_log[w0 % 16] === a_dir, "R7 directory written first", wr_log[w0 % 16], a_dir);
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R9 done single pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic place(input logic [19:0] base, input logic [31:0] va,
                       input logic [31:0] pde, input logic [31:0] pte);
    logic [31:0] a_dir, a_tbl;
    a_dir = {base, va[31:22], 2'b00};
    a_tbl = {pde[31:12], va[21:12], 2'b00};
    mem[a_dir[14:2]] = pde;
    mem[a_tbl[14:2]] = pte;
  endtask

  function automatic logic [11:0] rnd_flags();
    logic [11:0] f;
    f = 12'($urandom) & 12'h066;
    f[0] = ($urandom % 8) != 0;
    return f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
    rst = 1'b1; req_valid = 1'b0; dir_base = '0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 reset ready", {31'b0, req_ready}, 32'd1);
    chk(done === 1'b0, "R11 reset done", {31'b0, done}, 32'd0);
    chk(mem_req === 1'b0, "R11 reset mem_req", {31'b0, mem_req}, 32'd0);

    // Directed corner cases
    place(20'd0, 32'h0040_1123, 32'h0000_1006, 32'h0001_2067); walk(20'd0, 32'h0040_1123, 1'b0, 1'b0); // R3 dir absent
    place(20'd0, 32'h0080_2456, 32'h0000_2007, 32'h0001_3066); walk(20'd0, 32'h0080_2456, 1'b1, 1'b1); // R3 table absent
    place(20'd0, 32'h00C0_3789, 32'h0000_3003, 32'h0001_4007); walk(20'd0, 32'h00C0_3789, 1'b0, 1'b1); // R4 dir user
    place(20'd0, 32'h0100_4ABC, 32'h0000_1007, 32'h0001_5005); walk(20'd0, 32'h0100_4ABC, 1'b1, 1'b1); // R5 table write
    place(20'd0, 32'h0140_5DEF, 32'h0000_2001, 32'h0001_6001); walk(20'd0, 32'h0140_5DEF, 1'b1, 1'b0); // R5 supervisor write
    place(20'd0, 32'h0180_6001, 32'h0000_3027, 32'h0001_7027); walk(20'd0, 32'h0180_6001, 1'b0, 1'b1); // R7 nothing changes
    place(20'd0, 32'h01C0_7002, 32'h0000_1027, 32'h0001_8027); walk(20'd0, 32'h01C0_7002, 1'b1, 1'b1); // R7 table only
    place(20'd4, 32'hFFFF_FFFF, 32'h0000_2007, 32'hABCD_E007); walk(20'd4, 32'hFFFF_FFFF, 1'b1, 1'b1); // R1 R6 top address
    place(20'd0, 32'h0200_8003, 32'h0000_3001, 32'h0001_9007); walk(20'd0, 32'h0200_8003, 1'b1, 1'b1); // R4 over R5

    // Random walks
    for (int k = 0; k < 400; k++) begin
      logic [19:0] b;
      logic [31:0] v, pd, pt;
      b  = ($urandom % 2) ? 20'd4 : 20'd0;
      v  = $urandom;
      pd = {20'(1 + $urandom % 3), rnd_flags()};
      pt = {20'($urandom), rnd_flags()};
      place(b, v, pd, pt);
      walk(b, v, 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule